// File: doc/BRIEF.md
# Selectable Edge Trigger Router with Pulse Export

This block chooses one trigger source out of a small set under register control: a software strobe, the digital output of an analog comparator, a star trigger line, or any one of eight shared trigger bus lines. Every external line passes through its own two-flop synchroniser. The block watches the chosen line for the edge direction that software selected. Each qualifying edge yields a one-cycle internal trigger event. When export is enabled, the event also drives a front-panel trigger output pulse that lasts exactly two timebase clocks.

A register port loads source, polarity and export enable in one write. Any write blanks detection for the next cycle. This stops a switch of the multiplexer from looking like an edge. The edge detector uses two named states. MASK is entered on reset and on every write, and it leaves to ARMED on the first cycle with no write. ARMED stays in ARMED while there is no write and goes back to MASK on a write. The pulse generator also has two states. IDLE goes to HIGH on an exported event. HIGH reloads its count on a further exported event and drops back to IDLE once its count runs out.

Top module: `trig_route_top`

## Requirements
- R1: After reset, trig_evt and trig_out are 0, the source is the software strobe, polarity is rising, export is off, and detection is masked for the first cycle after reset is released.
- R2: Source codes on cfg_src are 0 software strobe, 1 analog level, 2 star line, and 3+j bus line j for j in 0..7. Codes 11 to 15 select nothing and never produce an event.
- R3: An external input that changes before clock edge k gives trig_evt high for the cycle after edge k+2 (two synchroniser flops plus one event register).
- R4: cfg_fall=0 detects rising edges and cfg_fall=1 detects falling edges. The opposite edge produces no event.
- R5: When code 0 is selected, sw_strobe high at an edge gives trig_evt high for the following cycle, and cfg_fall has no effect on it. The strobe is ignored under any other code.
- R6: Activity on lines that are not selected produces no event.
- R7: A register write (cfg_we high at an edge) suppresses detection during the next cycle. A level difference between the old and new source creates no event, and an edge that falls in that cycle is lost.
- R8: With cfg_exp_en=1, an event drives trig_out high starting the cycle after trig_evt, for exactly 2 cycles.
- R9: With cfg_exp_en=0, events still appear on trig_evt, and trig_out stays 0.
- R10: An exported event that arrives while trig_out is high restarts the 2-cycle count from that event, so the pulse ends 2 cycles after the later event.
- R11: One edge on an external line yields a single one-cycle trig_evt, however long the new level is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_src | input | 4 | Source code written on cfg_we |
| cfg_fall | input | 1 | Polarity written on cfg_we (1 = falling) |
| cfg_exp_en | input | 1 | Export enable written on cfg_we |
| sw_strobe | input | 1 | One-cycle software trigger |
| ana_lvl | input | 1 | Analog comparator output level |
| star_in | input | 1 | Star trigger line |
| bus_in | input | 8 | Shared trigger bus lines |
| trig_evt | output | 1 | One-cycle internal trigger event |
| trig_out | output | 1 | Exported front-panel trigger pulse |

## Verification
The assertions assume that every external line holds each level for at least two timebase cycles, which is the clock-domain form of the minimum external pulse width. The single-event property relies on this, so two edges can never be detected back to back. The stimulus holds every external level for three cycles or more. It raises the software strobe for one cycle at a time and raises cfg_we for one cycle per write, so all the properties apply to the traffic the bench drives.

// File: rtl/trig_route_pkg.sv
package trig_route_pkg;

    // Fixed source codes; bus line j uses SRC_BUS_BASE + j.
    localparam int SRC_SW_CODE   = 0;
    localparam int SRC_ANA_CODE  = 1;
    localparam int SRC_STAR_CODE = 2;
    localparam int SRC_BUS_BASE  = 3;

    typedef enum logic {
        ED_MASK  = 1'b0,
        ED_ARMED = 1'b1
    } edge_st_e;

    typedef enum logic {
        PL_IDLE = 1'b0,
        PL_HIGH = 1'b1
    } pulse_st_e;

endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs #(
    parameter int SRC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SRC_W-1:0] cfg_src,
    input  logic             cfg_fall,
    input  logic             cfg_exp_en,
    output logic [SRC_W-1:0] src_q,
    output logic             fall_q,
    output logic             exp_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            fall_q <= 1'b0;
            exp_q  <= 1'b0;
        end else if (cfg_we) begin
            src_q  <= cfg_src;
            fall_q <= cfg_fall;
            exp_q  <= cfg_exp_en;
        end
    end

endmodule

// File: rtl/trig_sync_bank.sv
module trig_sync_bank #(
    parameter int LINES  = 10,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] synced
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= '0;
            end else begin
                chain <= {chain[STAGES-2:0], raw[g]};
            end
        end

        assign synced[g] = chain[STAGES-1];
    end

endmodule

// File: rtl/trig_edge_det.sv
module trig_edge_det
    import trig_route_pkg::*;
#(
    parameter int NLINE = 10,
    parameter int SRC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SRC_W-1:0] src_q,
    input  logic             fall_q,
    input  logic             sw_strobe,
    input  logic [NLINE-1:0] lines,
    output logic             trig_evt
);

    edge_st_e st, st_nx;
    logic     sel_val;
    logic     line_ok;
    logic     prev;
    logic     hit;

    // Line i of the packed vector answers to source code i+1.
    always_comb begin
        sel_val = 1'b0;
        line_ok = 1'b0;
        for (int i = 0; i < NLINE; i++) begin
            if (int'(src_q) == i + 1) begin
                sel_val = lines[i];
                line_ok = 1'b1;
            end
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ED_MASK:  st_nx = cfg_we ? ED_MASK : ED_ARMED;
            ED_ARMED: st_nx = cfg_we ? ED_MASK : ED_ARMED;
            default:  st_nx = ED_MASK;
        endcase
    end

    always_comb begin
        hit = 1'b0;
        if (st == ED_ARMED) begin
            if (int'(src_q) == SRC_SW_CODE) begin
                hit = sw_strobe;
            end else if (line_ok) begin
                hit = fall_q ? (prev & ~sel_val) : (~prev & sel_val);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ED_MASK;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev     <= 1'b0;
            trig_evt <= 1'b0;
        end else begin
            prev     <= sel_val;
            trig_evt <= hit;
        end
    end

    p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> ##1 !trig_evt);

    p_sw_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_strobe && int'(src_q) == SRC_SW_CODE && st == ED_ARMED) |=> trig_evt);

    // Inputs hold each level for at least two cycles.
    p_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_evt && int'(src_q) != SRC_SW_CODE) |=> !trig_evt);

endmodule

// File: rtl/trig_pulse_gen.sv
module trig_pulse_gen
    import trig_route_pkg::*;
#(
    parameter int PULSE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic exp_en,
    output logic pulse_out
);

    localparam int CNT_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PULSE_CYC - 1);

    pulse_st_e        st, st_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             fire;

    assign fire = evt & exp_en;

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        unique case (st)
            PL_IDLE: begin
                if (fire) begin
                    st_nx  = PL_HIGH;
                    cnt_nx = RELOAD;
                end
            end
            PL_HIGH: begin
                if (fire) begin
                    cnt_nx = RELOAD;
                end else if (cnt == '0) begin
                    st_nx = PL_IDLE;
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
            default: st_nx = PL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= PL_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        pulse_out = (st == PL_HIGH);
    end

    p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && exp_en) |=> pulse_out);

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_out && !(evt && exp_en)) |=> !pulse_out);

endmodule

// File: rtl/trig_route_top.sv
module trig_route_top
    import trig_route_pkg::*;
#(
    parameter int BUS_W     = 8,
    parameter int SYNC_STG  = 2,
    parameter int PULSE_CYC = 2,
    localparam int NLINE    = BUS_W + 2,
    localparam int SRC_W    = $clog2(SRC_BUS_BASE + BUS_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SRC_W-1:0] cfg_src,
    input  logic             cfg_fall,
    input  logic             cfg_exp_en,
    input  logic             sw_strobe,
    input  logic             ana_lvl,
    input  logic             star_in,
    input  logic [BUS_W-1:0] bus_in,
    output logic             trig_evt,
    output logic             trig_out
);

    logic [SRC_W-1:0] src_q;
    logic             fall_q;
    logic             exp_q;
    logic [NLINE-1:0] raw_lines;
    logic [NLINE-1:0] sync_lines;

    assign raw_lines = {bus_in, star_in, ana_lvl};

    trig_cfg_regs #(.SRC_W(SRC_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_src   (cfg_src),
        .cfg_fall  (cfg_fall),
        .cfg_exp_en(cfg_exp_en),
        .src_q     (src_q),
        .fall_q    (fall_q),
        .exp_q     (exp_q)
    );

    trig_sync_bank #(.LINES(NLINE), .STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (raw_lines),
        .synced(sync_lines)
    );

    trig_edge_det #(.NLINE(NLINE), .SRC_W(SRC_W)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .src_q    (src_q),
        .fall_q   (fall_q),
        .sw_strobe(sw_strobe),
        .lines    (sync_lines),
        .trig_evt (trig_evt)
    );

    trig_pulse_gen #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (trig_evt),
        .exp_en   (exp_q),
        .pulse_out(trig_out)
    );

endmodule

// File: tb/tb_trig_route_top.sv
module tb_trig_route_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we;
    logic [3:0] cfg_src;
    logic       cfg_fall;
    logic       cfg_exp_en;
    logic       sw_strobe;
    logic       ana_lvl;
    logic       star_in;
    logic [7:0] bus_in;
    logic       trig_evt;
    logic       trig_out;

    always #4 clk = ~clk;

    trig_route_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_src(cfg_src),
        .cfg_fall(cfg_fall), .cfg_exp_en(cfg_exp_en), .sw_strobe(sw_strobe),
        .ana_lvl(ana_lvl), .star_in(star_in), .bus_in(bus_in),
        .trig_evt(trig_evt), .trig_out(trig_out)
    );

    int    total = 0;
    int    bad   = 0;
    int    cyc   = 0;
    bit    done  = 0;
    string cur_req = "R1";

    // Behavioural reference state
    int   m_src;
    bit   m_fall, m_en, m_mask, m_prev, m_evt;
    int   m_left;
    bit [9:0] m_s1, m_s2;

    function automatic bit pick(input bit [9:0] v, input int code, output bit ok);
        ok = 1'b1;
        if (code == 1)                    return v[0];
        if (code == 2)                    return v[1];
        if (code >= 3 && code <= 10)      return v[code - 1];
        ok = 1'b0;
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_src = 0; m_fall = 0; m_en = 0; m_mask = 1; m_prev = 0;
            m_evt = 0; m_left = 0; m_s1 = '0; m_s2 = '0;
        end else begin
            bit ok, cur, det;
            cur = pick(m_s2, m_src, ok);
            det = 0;
            if (!m_mask) begin
                if (m_src == 0) det = sw_strobe;
                else if (ok)    det = m_fall ? (m_prev && !cur) : (!m_prev && cur);
            end
            if (m_evt && m_en)  m_left = 2;
            else if (m_left > 0) m_left = m_left - 1;
            m_evt  = det;
            m_prev = cur;
            m_mask = cfg_we;
            if (cfg_we) begin
                m_src = int'(cfg_src); m_fall = cfg_fall; m_en = cfg_exp_en;
            end
            m_s2 = m_s1;
            m_s1 = {bus_in, star_in, ana_lvl};
        end
    end

    task automatic check(input string what, input bit act, input bit exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0b exp=%0b cycle=%0d", cur_req, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            cyc++;
            if (rst_n) begin
                check("trig_evt", trig_evt, m_evt);
                check("trig_out", trig_out, m_left > 0);
            end
            if (cyc > 20000) begin
                total++; bad++;
                $display("FAIL %s watchdog act=%0d exp=<20000", cur_req, cyc);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    task automatic step(input int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wr(input int src, input bit fall, input bit en);
        cfg_src = 4'(src); cfg_fall = fall; cfg_exp_en = en; cfg_we = 1'b1;
        step(1);
        cfg_we = 1'b0;
        step(2);
    endtask

    task automatic strobe();
        sw_strobe = 1'b1;
        step(1);
        sw_strobe = 1'b0;
    endtask

    task automatic toggle_star(input int hold);
        star_in = ~star_in; step(hold);
        star_in = ~star_in; step(hold);
    endtask

    initial begin
        rst_n = 0; cfg_we = 0; cfg_src = 0; cfg_fall = 0; cfg_exp_en = 0;
        sw_strobe = 0; ana_lvl = 0; star_in = 0; bus_in = '0;
        step(3);
        // R1: outputs idle in reset, strobe in first masked cycle ignored
        check("trig_evt in reset R1", trig_evt, 1'b0);
        check("trig_out in reset R1", trig_out, 1'b0);
        cur_req = "R1";
        rst_n = 1;
        strobe();
        step(3);

        cur_req = "R5";                     // default source, export off
        strobe(); step(3);
        cur_req = "R8";
        wr(0, 0, 1); strobe(); step(4);
        cur_req = "R5";                     // polarity ignored for strobe
        wr(0, 1, 1); strobe(); step(4);

        cur_req = "R3";                     // star rising, falling ignored (R4)
        wr(2, 0, 1); toggle_star(6);
        cur_req = "R4";
        wr(2, 1, 1); toggle_star(6);
        cur_req = "R5";                     // strobe ignored on star
        strobe(); step(3);

        cur_req = "R2";                     // analog level
        wr(1, 0, 1);
        ana_lvl = 1; step(5); ana_lvl = 0; step(5);

        for (int j = 0; j < 8; j++) begin
            cur_req = "R6";
            wr(3 + j, j % 2, 1);
            star_in = ~star_in; bus_in[(j + 1) % 8] = ~bus_in[(j + 1) % 8];
            ana_lvl = ~ana_lvl; step(4);
            cur_req = "R2";
            bus_in[j] = ~bus_in[j]; step(4);
            bus_in[j] = ~bus_in[j]; step(4);
        end
        bus_in = '0; ana_lvl = 0; star_in = 0; step(4);

        cur_req = "R2";                     // unused code selects nothing
        wr(12, 0, 1);
        star_in = 1; ana_lvl = 1; bus_in = 8'hFF; strobe(); step(4);
        star_in = 0; ana_lvl = 0; bus_in = 8'h00; step(4);

        cur_req = "R9";
        wr(2, 0, 0); toggle_star(5);

        cur_req = "R7";                     // level difference on switch
        wr(2, 0, 1);
        bus_in[0] = 1; step(4);
        wr(3, 0, 1); step(4);
        bus_in[0] = 0; step(4); bus_in[0] = 1; step(4); bus_in[0] = 0; step(4);
        // real edge lands in masked cycle
        wr(2, 0, 1);
        star_in = 1; step(1);
        cfg_src = 4'd2; cfg_fall = 0; cfg_exp_en = 1; cfg_we = 1; step(1);
        cfg_we = 0; step(5);
        star_in = 0; step(5);

        cur_req = "R10";                    // retrigger during pulse
        wr(0, 0, 1);
        strobe(); step(1); strobe(); step(5);
        strobe(); strobe(); step(5);

        cur_req = "R11";                    // long hold, single event
        wr(2, 0, 1);
        star_in = 1; step(20); star_in = 0; step(6);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule